// File: doc/BRIEF.md
# Overlapped Hann-Windowed Frame Generator

This block sits in front of a pair of streaming FFT engines. It takes one uninterrupted stream of 12-bit signed samples, one per clock, and produces two windowed 16-bit streams. Both streams are multiplied by a Hann window whose coefficients sit in a ROM. The ROM contents are computed when the design is elaborated.

The second stream is the input delayed by half a frame. Both streams step through the same window position on the same clock, so their frames start together at the output. In input time, however, the second stream's frames begin half a frame earlier. The two frame sequences therefore overlap by 50%, with no input sample skipped. Each stream carries a valid flag and a start-of-frame pulse. The second stream's valid flag stays low until its first complete frame has been assembled. The frame length is a parameter; 1024 is the default, and 256 and 512 are also intended values.

Top module: `hann_overlap_framer`

## Requirements
- R1: A synchronous reset, active high, clears both valid flags and both start-of-frame pulses at the clock edge where it is sampled. The first sample taken after reset is released becomes window index 0 of stream A.
- R2: A sample captured at clock edge i appears as stream A output after edge i+1, a latency of two registers.
- R3: The window coefficient at index n is the unsigned Q1.15 value round(32768*(0.5-0.5*cos(2*pi*n/N))). Examples are 0 at n=0, 16384 at n=N/4 and 32768 at n=N/2.
- R4: Each output is computed as (sample*coefficient + 1024) >>> 11, taken as a 16-bit signed value. For example, 2047 at coefficient 32768 gives 32752, and -2048 gives -32768.
- R5: The output at window index 0 is exactly zero on both streams, whatever the sample.
- R6: a_sof is high on index 0 of every stream A frame, once every N samples, and low otherwise.
- R7: Stream B carries the input delayed by exactly N/2 samples. It is windowed with the same coefficient index as stream A in the same cycle. b_sof is high exactly when a_sof is high and b_valid is high.
- R8: b_valid is low for the first N outputs after reset. It is high from the output of input sample N onward and stays high.
- R9: a_valid is high for every output after reset, starting with sample 0, with no gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 12 | Signed input sample, one per clock |
| a_data | output | 16 | Windowed sample, stream A |
| a_valid | output | 1 | Stream A sample valid |
| a_sof | output | 1 | Stream A window index 0 |
| b_data | output | 16 | Windowed half-frame-delayed sample, stream B |
| b_valid | output | 1 | Stream B sample valid |
| b_sof | output | 1 | Stream B window index 0 |

## Verification
On even frames the input repeats a short table of extreme and small values: full scale, most negative, zero, plus and minus one, and mid values. These land at index 0, the quarter point and the window centre, where they separate rounding errors, sign-extension faults and wrong coefficients. On odd frames a pseudo-random pattern runs, so a wrong delay length or a swapped stream shows up as a data mismatch on stream B. A reset in the middle of a run shows whether the position counter and the delay-fill state restart. After that reset, b_valid must again stay low for a full frame.

// File: rtl/hann_overlap_framer.sv
module hann_overlap_framer #(
  parameter int FRAME_LEN = 1024,
  parameter int IN_W      = 12,
  parameter int COEF_W    = 16,
  parameter int OUT_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] a_data,
  output logic                    a_valid,
  output logic                    a_sof,
  output logic signed [OUT_W-1:0] b_data,
  output logic                    b_valid,
  output logic                    b_sof
);
  localparam int  AW    = $clog2(FRAME_LEN);
  localparam int  HALF  = FRAME_LEN / 2;
  localparam int  PW    = IN_W + COEF_W + 1;
  localparam int  SHIFT = IN_W - 1;
  localparam real PI    = 3.14159265358979323846;

  function automatic logic [COEF_W-1:0] hann(input int n);
    real w;
    w = 0.5 - 0.5 * $cos(2.0 * PI * $itor(n) / $itor(FRAME_LEN));
    return COEF_W'($rtoi(w * $itor(1 << (COEF_W - 1)) + 0.5));
  endfunction

  logic [COEF_W-1:0] win [FRAME_LEN];
  initial begin
    for (int i = 0; i < FRAME_LEN; i++) win[i] = hann(i);
  end

  logic signed [IN_W-1:0] dly [HALF];

  logic [AW-1:0]          pos;
  logic                   b_live;
  logic signed [IN_W-1:0] s_a, s_b;
  logic [COEF_W-1:0]      coef;
  logic                   v_a, v_b, sof1;
  logic signed [PW-1:0]   pa, pb;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos    <= '0;
      b_live <= 1'b0;
      v_a    <= 1'b0;
      v_b    <= 1'b0;
      sof1   <= 1'b0;
    end else begin
      pos  <= pos + 1'b1;
      v_a  <= 1'b1;
      v_b  <= b_live;
      sof1 <= (pos == '0);
      if (pos == AW'(FRAME_LEN - 1)) b_live <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    s_a  <= din;
    coef <= win[pos];
    s_b  <= dly[pos[AW-2:0]];
    dly[pos[AW-2:0]] <= din;
  end

  assign pa = $signed(s_a) * $signed({1'b0, coef}) + PW'(1 << (SHIFT - 1));
  assign pb = $signed(s_b) * $signed({1'b0, coef}) + PW'(1 << (SHIFT - 1));

  always_ff @(posedge clk) begin
    a_data <= OUT_W'(pa >>> SHIFT);
    b_data <= OUT_W'(pb >>> SHIFT);
    if (rst) begin
      a_valid <= 1'b0;
      b_valid <= 1'b0;
      a_sof   <= 1'b0;
      b_sof   <= 1'b0;
    end else begin
      a_valid <= v_a;
      b_valid <= v_b;
      a_sof   <= sof1 & v_a;
      b_sof   <= sof1 & v_b;
    end
  end

  p_sof_valid_r6: assert property (@(posedge clk) disable iff (rst) a_sof |-> a_valid);
  p_a_steady_r9: assert property (@(posedge clk) disable iff (rst) a_valid |=> a_valid);
  p_b_steady_r8: assert property (@(posedge clk) disable iff (rst) b_valid |=> b_valid);
  p_b_sof_aligned_r7: assert property (@(posedge clk) disable iff (rst) b_sof |-> (a_sof && b_valid));
  p_a_edge_zero_r5: assert property (@(posedge clk) disable iff (rst) a_sof |-> (a_data == '0));
  p_b_edge_zero_r5: assert property (@(posedge clk) disable iff (rst) b_sof |-> (b_data == '0));
endmodule

// File: tb/test_hann_overlap_framer.sv
module test_hann_overlap_framer;
  localparam int  N  = 1024;
  localparam int  H  = N / 2;
  localparam real PI = 3.14159265358979323846;
  localparam logic signed [11:0] VEC [16] = '{
    12'sd2047, -12'sd2048, 12'sd0, 12'sd1, -12'sd1, 12'sd1024, -12'sd1024, 12'sd2046,
    -12'sd2047, 12'sd3, -12'sd3, 12'sd511, -12'sd512, 12'sd100, -12'sd100, 12'sd1365};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [11:0] din = '0;
  logic signed [15:0] a_data, b_data;
  logic a_valid, a_sof, b_valid, b_sof;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  int hist [4096];

  always #2 clk = ~clk;

  hann_overlap_framer i_hann_overlap_framer (
    .clk(clk), .rst(rst), .din(din),
    .a_data(a_data), .a_valid(a_valid), .a_sof(a_sof),
    .b_data(b_data), .b_valid(b_valid), .b_sof(b_sof));

  function automatic longint wexp(input int n);
    real w;
    w = 0.5 - 0.5 * $cos(2.0 * PI * $itor(n) / $itor(N));
    return longint'($rtoi(w * 32768.0 + 0.5));
  endfunction

  function automatic longint rnd(input longint s, input longint c);
    return (s * c + 1024) >>> 11;
  endfunction

  function automatic int gen(input int k);
    if (((k / N) % 2) == 0) return int'(VEC[k % 16]);
    return ((k * 1103 + 12345) % 4096) - 2048;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_idx(input int j);
    int n = j % N;
    longint c = wexp(n);
    chk("R2 R4 a_data", longint'(a_data), rnd(hist[j], c));
    chk("R9 a_valid", longint'(a_valid), 1);
    chk("R6 a_sof", longint'(a_sof), (n == 0) ? 1 : 0);
    chk("R8 b_valid", longint'(b_valid), (j >= N) ? 1 : 0);
    chk("R7 b_sof", longint'(b_sof), (n == 0 && j >= N) ? 1 : 0);
    if (j >= N) chk("R7 b_data", longint'(b_data), rnd(hist[j - H], c));
    if (n == 0) chk("R5 a_data zero", longint'(a_data), 0);
    if (n == 0 && j >= N) chk("R5 b_data zero", longint'(b_data), 0);
    if (n == H) chk("R3 centre coef", longint'(a_data), rnd(hist[j], 32768));
    if (n == N / 4) chk("R3 quarter coef", longint'(a_data), rnd(hist[j], 16384));
  endtask

  task automatic run(input int total);
    for (int k = 0; k < total + 2; k++) begin
      @(negedge clk);
      if (k == 0) begin
        chk("R1 a_valid in reset", longint'(a_valid), 0);
        chk("R1 b_valid in reset", longint'(b_valid), 0);
        chk("R1 a_sof in reset", longint'(a_sof), 0);
        chk("R1 b_sof in reset", longint'(b_sof), 0);
        rst = 1'b0;
      end else if (k == 1) begin
        chk("R1 a_valid before first sample", longint'(a_valid), 0);
      end else begin
        check_idx(k - 2);
      end
      if (k < total) begin
        hist[k] = gen(k);
        din = 12'(gen(k));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    run(3 * N + 8);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R1 mid-run reset a_valid", longint'(a_valid), 0);
    chk("R1 mid-run reset b_valid", longint'(b_valid), 0);
    chk("R1 mid-run reset a_sof", longint'(a_sof), 0);
    run(N + 8);
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule